// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This block sits inside a memory controller next to the ECC decoder. The decoder reports each correctable error (CE) or uncorrectable error (UE) as a one-cycle strobe. The strobe comes with the failing 36-bit address, the 64-bit raw data word, an 8-bit syndrome and a 13-bit requester ID. For each error class the block keeps one snapshot of these details. It also keeps two event flags per class. The first-event flag marks that the snapshot is valid. The second-event flag marks that another error of the same class arrived before software acknowledged the first. That later error is flagged but does not overwrite the snapshot.

Software reaches the block through a plain 32-bit register port. Writes are strobed and reads are combinational. Software reads the status word and fetches the snapshot. It then writes ones to an acknowledge register to drop individual flags. A mask register selects which flags may raise the registered interrupt output.

Each class is tracked by a small state machine. Its states are CLEAR (no flag), FIRST (snapshot held), BOTH (snapshot held and overrun seen) and SECOND (overrun flag left after the first flag was acknowledged). The transitions are:
- CLEAR→FIRST on an error, which loads the snapshot.
- FIRST→BOTH on an error.
- FIRST→CLEAR on an acknowledge of the first flag.
- BOTH→SECOND on an acknowledge of the first flag.
- BOTH→FIRST on an acknowledge of the second flag.
- SECOND→CLEAR on an acknowledge of the second flag.
- SECOND→FIRST or BOTH on an error, which reloads the snapshot.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every status flag and snapshot field is zero, `irq` is 0, and the mask register reads 0x0000_0078 (all four sources disabled).
- R2: A CE strobe while the CE first flag (status bit 3 at offset 0x210) is clear loads the CE snapshot and sets bit 3. The snapshot reads as follows:
  - 0x190 holds address bits 31..0.
  - 0x194 holds address bits 35..32 in bits 3..0 and the syndrome in bits 15..8.
  - 0x198 holds data bits 31..0 and 0x19C holds data bits 63..32.
  - Offset 0x1A0 holds the CE requester ID in bits 28..16.
- R3: A UE strobe while the UE first flag (status bit 5) is clear loads the UE snapshot and sets bit 5. The snapshot uses the same layout at 0x180, 0x184, 0x188 and 0x18C, and the UE requester ID is in bits 12..0 of 0x1A0.
- R4: A strobe of a class whose first flag is already set leaves that class's snapshot unchanged and sets the second flag: bit 4 for CE, bit 6 for UE.
- R5: Writing to offset 0x218 clears each status bit 6..3 written as 1 and leaves the bits written as 0 unchanged. Offset 0x218 reads as zero.
- R6: When a strobe and an acknowledge of the status bit that strobe sets fall in the same cycle, the bit ends set.
- R7: Mask bits 6..3 at offset 0x220 disable the matching status bit when 1. `irq` is registered and equals the OR over bits 6..3 of (status AND NOT mask) as they stood one cycle earlier.
- R8: Unmapped offsets and unused bit positions read as zero. Writes to the snapshot offsets, the status offset and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_ce | input | 1 | Correctable-error strobe from the decoder |
| rpt_ue | input | 1 | Uncorrectable-error strobe from the decoder |
| rpt_addr | input | 36 | Failing address |
| rpt_data | input | 64 | Raw data word as read |
| rpt_synd | input | 8 | ECC syndrome |
| rpt_id | input | 13 | Requester ID |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Registered interrupt request |

## Verification
Properties check on every cycle the behaviour that a single edge decides:
- a strobe on a clear class loads the snapshot and sets the first flag;
- a strobe on a held class keeps the snapshot and sets the overrun flag;
- an acknowledge clears its flag unless a strobe targets the same bit;
- a fully masked unit keeps `irq` low;
- high offsets read zero.

Only the bench's scenarios can show the whole register image across multi-step histories. It sweeps every tracker state against every acknowledge pattern, with and without a strobe. It also sweeps all sixteen mask settings against full status and checks that stray writes leave every readable word intact.

// File: rtl/ecclog_pkg.sv
`timescale 1ns/1ps
package ecclog_pkg;
    // Per-class tracker state; bit 0 = first flag, bit 1 = overrun flag
    typedef enum logic [1:0] {
        TRK_CLEAR  = 2'b00,
        TRK_FIRST  = 2'b01,
        TRK_BOTH   = 2'b11,
        TRK_SECOND = 2'b10
    } trk_state_e;

    localparam logic [11:0] OFF_UE_BASE = 12'h180;
    localparam logic [11:0] OFF_CE_BASE = 12'h190;
    localparam logic [11:0] OFF_ID      = 12'h1A0;
    localparam logic [11:0] OFF_STAT    = 12'h210;
    localparam logic [11:0] OFF_ACK     = 12'h218;
    localparam logic [11:0] OFF_MASK    = 12'h220;

    localparam int EVT_LSB   = 3;   // status bit of the CE first flag
    localparam int NUM_EVT   = 4;   // CE first, CE second, UE first, UE second
    localparam int SYND_LSB  = 8;
    localparam int CEID_LSB  = 16;
endpackage

// File: rtl/ecclog_tracker.sv
`timescale 1ns/1ps
module ecclog_tracker
    import ecclog_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64,
    parameter int SYND_W = 8,
    parameter int ID_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              ack_first,
    input  logic              ack_second,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SYND_W-1:0] in_synd,
    input  logic [ID_W-1:0]   in_id,
    output logic              flag_first,
    output logic              flag_second,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DATA_W-1:0] log_data,
    output logic [SYND_W-1:0] log_synd,
    output logic [ID_W-1:0]   log_id
);
    trk_state_e state_q, state_d;
    logic       load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            TRK_CLEAR: begin
                load    = evt;
                state_d = evt ? TRK_FIRST : TRK_CLEAR;
            end
            TRK_FIRST:  state_d = trk_state_e'({evt, ~ack_first});
            TRK_BOTH:   state_d = trk_state_e'({evt | ~ack_second, ~ack_first});
            TRK_SECOND: begin
                load    = evt;
                state_d = trk_state_e'({~ack_second, evt});
            end
        endcase
    end

    always_comb begin
        flag_first  = (state_q == TRK_FIRST) || (state_q == TRK_BOTH);
        flag_second = (state_q == TRK_BOTH)  || (state_q == TRK_SECOND);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_addr <= '0;
            log_data <= '0;
            log_synd <= '0;
            log_id   <= '0;
        end else if (load) begin
            log_addr <= in_addr;
            log_data <= in_data;
            log_synd <= in_synd;
            log_id   <= in_id;
        end
    end
endmodule

// File: rtl/ecclog_readmux.sv
`timescale 1ns/1ps
module ecclog_readmux
    import ecclog_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64,
    parameter int SYND_W = 8,
    parameter int ID_W   = 13
) (
    input  logic [11:0]         reg_addr,
    input  logic [ADDR_W-1:0]   ce_addr,
    input  logic [DATA_W-1:0]   ce_data,
    input  logic [SYND_W-1:0]   ce_synd,
    input  logic [ID_W-1:0]     ce_id,
    input  logic [ADDR_W-1:0]   ue_addr,
    input  logic [DATA_W-1:0]   ue_data,
    input  logic [SYND_W-1:0]   ue_synd,
    input  logic [ID_W-1:0]     ue_id,
    input  logic [NUM_EVT-1:0]  status,
    input  logic [NUM_EVT-1:0]  mask,
    output logic [31:0]         rdata
);
    localparam int AHI_W = ADDR_W - 32;

    logic [31:0] ce_hi_word, ue_hi_word, id_word, stat_word, mask_word;

    always_comb begin
        ce_hi_word = '0;
        ce_hi_word[AHI_W-1:0]            = ce_addr[ADDR_W-1:32];
        ce_hi_word[SYND_LSB +: SYND_W]   = ce_synd;
        ue_hi_word = '0;
        ue_hi_word[AHI_W-1:0]            = ue_addr[ADDR_W-1:32];
        ue_hi_word[SYND_LSB +: SYND_W]   = ue_synd;
        id_word = '0;
        id_word[CEID_LSB +: ID_W]        = ce_id;
        id_word[ID_W-1:0]                = ue_id;
        stat_word = '0;
        stat_word[EVT_LSB +: NUM_EVT]    = status;
        mask_word = '0;
        mask_word[EVT_LSB +: NUM_EVT]    = mask;
    end

    always_comb begin
        case (reg_addr)
            OFF_UE_BASE:         rdata = ue_addr[31:0];
            OFF_UE_BASE + 12'h4: rdata = ue_hi_word;
            OFF_UE_BASE + 12'h8: rdata = ue_data[31:0];
            OFF_UE_BASE + 12'hC: rdata = ue_data[63:32];
            OFF_CE_BASE:         rdata = ce_addr[31:0];
            OFF_CE_BASE + 12'h4: rdata = ce_hi_word;
            OFF_CE_BASE + 12'h8: rdata = ce_data[31:0];
            OFF_CE_BASE + 12'hC: rdata = ce_data[63:32];
            OFF_ID:              rdata = id_word;
            OFF_STAT:            rdata = stat_word;
            OFF_MASK:            rdata = mask_word;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_logger.sv
`timescale 1ns/1ps
module ecc_err_logger
    import ecclog_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 64,
    parameter int SYND_W = 8,
    parameter int ID_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpt_ce,
    input  logic              rpt_ue,
    input  logic [ADDR_W-1:0] rpt_addr,
    input  logic [DATA_W-1:0] rpt_data,
    input  logic [SYND_W-1:0] rpt_synd,
    input  logic [ID_W-1:0]   rpt_id,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int NUM_CLS = 2;   // class 0 = CE, class 1 = UE

    logic [NUM_EVT-1:0] ack_vec;
    logic [NUM_EVT-1:0] status;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_CLS-1:0] evt_vec;
    logic [ADDR_W-1:0]  log_addr [NUM_CLS];
    logic [DATA_W-1:0]  log_data [NUM_CLS];
    logic [SYND_W-1:0]  log_synd [NUM_CLS];
    logic [ID_W-1:0]    log_id   [NUM_CLS];
    logic               unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:EVT_LSB+NUM_EVT], reg_wdata[EVT_LSB-1:0]};
    assign evt_vec = {rpt_ue, rpt_ce};
    assign ack_vec = (reg_we && reg_addr == OFF_ACK) ? reg_wdata[EVT_LSB +: NUM_EVT] : '0;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        ecclog_tracker #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W), .ID_W(ID_W)
        ) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (evt_vec[c]),
            .ack_first  (ack_vec[2*c]),
            .ack_second (ack_vec[2*c+1]),
            .in_addr    (rpt_addr),
            .in_data    (rpt_data),
            .in_synd    (rpt_synd),
            .in_id      (rpt_id),
            .flag_first (status[2*c]),
            .flag_second(status[2*c+1]),
            .log_addr   (log_addr[c]),
            .log_data   (log_data[c]),
            .log_synd   (log_synd[c]),
            .log_id     (log_id[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= '1;
        else if (reg_we && reg_addr == OFF_MASK) mask_q <= reg_wdata[EVT_LSB +: NUM_EVT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & ~mask_q);
    end

    ecclog_readmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W), .ID_W(ID_W)
    ) u_rd (
        .reg_addr(reg_addr),
        .ce_addr (log_addr[0]),
        .ce_data (log_data[0]),
        .ce_synd (log_synd[0]),
        .ce_id   (log_id[0]),
        .ue_addr (log_addr[1]),
        .ue_data (log_data[1]),
        .ue_synd (log_synd[1]),
        .ue_id   (log_id[1]),
        .status  (status),
        .mask    (mask_q),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/ecclog_checker.sv
`timescale 1ns/1ps
module ecclog_checker
    import ecclog_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rpt_ce,
    input logic              rpt_ue,
    input logic [ADDR_W-1:0] rpt_addr,
    input logic              reg_we,
    input logic [11:0]       reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              irq,
    input logic [3:0]        status,
    input logic [3:0]        mask_q,
    input logic [ADDR_W-1:0] ce_log_addr
);
    logic ack_wr;
    assign ack_wr = reg_we && (reg_addr == OFF_ACK);

    p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_ce && !status[0]) |=> (status[0] && ce_log_addr == $past(rpt_addr)));

    p_ue_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_ue && !status[2]) |=> status[2]);

    p_keep_log_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_ce && status[0]) |=> (status[1] && $stable(ce_log_addr)));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && reg_wdata[3] && !rpt_ce) |=> !status[0]);

    p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_ue && !status[2] && ack_wr && reg_wdata[5]) |=> status[2]);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'hF) |=> !irq);

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > OFF_MASK) |-> (reg_rdata == 32'h0));
endmodule

bind ecc_err_logger ecclog_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rpt_ce     (rpt_ce),
    .rpt_ue     (rpt_ue),
    .rpt_addr   (rpt_addr),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .status     (status),
    .mask_q     (mask_q),
    .ce_log_addr(log_addr[0])
);

// File: tb/test_ecc_err_logger.sv
`timescale 1ns/1ps
module test_ecc_err_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_ce = 1'b0, rpt_ue = 1'b0;
    logic [35:0] rpt_addr = '0;
    logic [63:0] rpt_data = '0;
    logic [7:0]  rpt_synd = '0;
    logic [12:0] rpt_id = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0, errors = 0, evt_no = 0;
    bit done = 0;

    // bench model; st[0]=CE first, st[1]=CE second, st[2]=UE first, st[3]=UE second
    logic [3:0]  st = '0, m = 4'hF;
    logic        exp_irq = 1'b0;
    logic [35:0] ce_a = '0, ue_a = '0;
    logic [63:0] ce_d = '0, ue_d = '0;
    logic [7:0]  ce_s = '0, ue_s = '0;
    logic [12:0] ce_i = '0, ue_i = '0;

    always #2 clk = ~clk;   // 250 MHz

    ecc_err_logger i_ecc_err_logger (
        .clk(clk), .rst_n(rst_n), .rpt_ce(rpt_ce), .rpt_ue(rpt_ue),
        .rpt_addr(rpt_addr), .rpt_data(rpt_data), .rpt_synd(rpt_synd), .rpt_id(rpt_id),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_rd(input logic [11:0] o);
        case (o)
            12'h180: return ue_a[31:0];
            12'h184: return {16'h0, ue_s, 4'h0, ue_a[35:32]};
            12'h188: return ue_d[31:0];
            12'h18C: return ue_d[63:32];
            12'h190: return ce_a[31:0];
            12'h194: return {16'h0, ce_s, 4'h0, ce_a[35:32]};
            12'h198: return ce_d[31:0];
            12'h19C: return ce_d[63:32];
            12'h1A0: return {3'b0, ce_i, 3'b0, ue_i};
            12'h210: return {25'h0, st, 3'b0};
            12'h220: return {25'h0, m, 3'b0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] o);
        if (o >= 12'h180 && o < 12'h190) return "R3";
        if (o >= 12'h190 && o < 12'h1A0) return "R2";
        if (o == 12'h1A0) return "R2 R3 id";
        if (o == 12'h210) return "R4 R5 R6 status";
        if (o == 12'h220) return "R7 mask";
        return "R8";
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // one clock: inputs applied at a falling edge, model follows the rising edge
    task automatic step(input bit ce, input bit ue, input bit we,
                        input logic [11:0] wa, input logic [31:0] wd);
        logic [3:0] ack;
        logic       nf, ns;
        evt_no++;
        rpt_ce = ce; rpt_ue = ue; reg_we = we; reg_addr = wa; reg_wdata = wd;
        rpt_addr = {4'(evt_no * 3), 32'(evt_no * 32'h0101_0101 + 5)};
        rpt_data = {32'(~evt_no), 32'(evt_no * 7)};
        rpt_synd = 8'(evt_no + 3);
        rpt_id   = 13'(evt_no * 97);
        ack = (we && wa == 12'h218) ? wd[6:3] : 4'h0;
        exp_irq = |(st & ~m);
        if (ce && !st[0]) begin
            ce_a = rpt_addr; ce_d = rpt_data; ce_s = rpt_synd; ce_i = rpt_id;
        end
        if (ue && !st[2]) begin
            ue_a = rpt_addr; ue_d = rpt_data; ue_s = rpt_synd; ue_i = rpt_id;
        end
        nf = (ce & ~st[0]) | (st[0] & ~ack[0]);
        ns = (ce & st[0])  | (st[1] & ~ack[1]);
        st[1:0] = {ns, nf};
        nf = (ue & ~st[2]) | (st[2] & ~ack[2]);
        ns = (ue & st[2])  | (st[3] & ~ack[3]);
        st[3:2] = {ns, nf};
        if (we && wa == 12'h220) m = wd[6:3];
        @(negedge clk);
        rpt_ce = 1'b0; rpt_ue = 1'b0; reg_we = 1'b0;
    endtask

    // full register image compare; irq checked first, then allowed to settle
    task automatic check_all(input string ctx);
        check(irq === exp_irq, {ctx, " R7 irq"}, 32'(irq), 32'(exp_irq));
        for (int o = 0; o < 1024; o += 4) begin
            reg_addr = 12'(o);
            #1;
            check(reg_rdata === exp_rd(12'(o)),
                  $sformatf("%s %s off=%h", ctx, tag_of(12'(o)), o), reg_rdata, exp_rd(12'(o)));
        end
        #1;
        @(negedge clk);
        exp_irq = |(st & ~m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 R3 first capture, then R4 overrun keeps snapshot
        step(1, 0, 0, 12'h0, 32'h0);
        check_all("R2 CE first");
        step(0, 1, 0, 12'h0, 32'h0);
        check_all("R3 UE first");
        step(1, 1, 0, 12'h0, 32'h0);
        check_all("R4 overrun");

        // R4 R5 R6: every tracker state x every ack pattern x strobe or not
        for (int cls = 0; cls < 2; cls++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 4; a++)
                    for (int e = 0; e < 2; e++) begin
                        step(0, 0, 1, 12'h218, 32'h78);
                        if (s >= 2) begin
                            step(cls == 0, cls == 1, 0, 12'h0, 32'h0);
                            step(cls == 0, cls == 1, 0, 12'h0, 32'h0);
                            if (s[0] == 1'b0)
                                step(0, 0, 1, 12'h218, 32'h1 << (3 + 2*cls));
                        end else if (s[0]) begin
                            step(cls == 0, cls == 1, 0, 12'h0, 32'h0);
                        end
                        step((e == 1) && (cls == 0), (e == 1) && (cls == 1), 1, 12'h218,
                             32'(a) << (3 + 2*cls));
                        check_all("R4 R5 R6 sweep");
                    end

        // R7: all sixteen masks against full status
        step(1, 1, 0, 12'h0, 32'h0);
        step(1, 1, 0, 12'h0, 32'h0);
        for (int mv = 0; mv < 16; mv++) begin
            step(0, 0, 1, 12'h220, 32'(mv) << 3);
            check_all("R7 mask sweep");
        end

        // R7 latency: status sets on edge k, irq rises on edge k+1
        step(0, 0, 1, 12'h218, 32'h78);
        step(0, 0, 1, 12'h220, 32'h0);
        step(0, 0, 0, 12'h0, 32'h0);
        step(1, 0, 0, 12'h0, 32'h0);
        check(irq === 1'b0, "R7 latency edge k", 32'(irq), 32'h0);
        step(0, 0, 0, 12'h0, 32'h0);
        check(irq === 1'b1, "R7 latency edge k+1", 32'(irq), 32'h1);

        // R8: stray writes change nothing
        step(0, 1, 0, 12'h0, 32'h0);
        for (int o = 12'h180; o <= 12'h1A0; o += 4) step(0, 0, 1, 12'(o), 32'hFFFF_FFFF);
        step(0, 0, 1, 12'h210, 32'hFFFF_FFFF);
        step(0, 0, 1, 12'h3FC, 32'hFFFF_FFFF);
        step(0, 0, 1, 12'h214, 32'h0000_0078);
        check_all("R8 writes");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule